// File: doc/BRIEF.md
# Cascadable Byte Timer Bank

This block holds four 8-bit down-counting timers behind one byte-addressed register port. Each timer has a mode byte, a reload byte and a counter byte that can only be read. A timer whose mode selects the internal clock and has the enable bit set counts down by one in every cycle where the shared `tick` input is high. When it reaches the end of its period, it reloads from its reload byte and emits a one-cycle underflow pulse.

Any timer other than timer 0 can be switched into chain mode. It then joins the timer below it to form one wider counter of 16, 24 or 32 bits. The lowest timer in the chain holds the least-significant byte, and only the highest timer in the chain pulses its underflow output. Software reaches one, two or four neighbouring timers in a single access. Any access that breaks the rules pulses `errPulse` and changes no state.

Top module: `tmr_bank`

## Requirements
- R1: After reset every mode, reload and counter byte reads as 0x00, and `uflow` and `errPulse` are low.
- R2: A mode byte with bit 7 (enable) and bit 6 (load) both set, or with any of bits 5:2 set, is illegal. The whole access is discarded and `errPulse` goes high in the following cycle.
- R3: A write to a reload byte while that timer's enable bit is clear also sets its counter. While the timer runs, the new reload value is used only from the next underflow reload onward.
- R4: A running timer with reload value B counts B, B-1, …, 1 and then returns to B. This gives one `uflow` pulse every B ticks, in the cycle after the tick that ends the period. Whenever a timer's enable bit is clear, its counter reads its reload value. Any mode write that leaves the enable bit clear reloads the counter.
- R5: Mode bits 1:0 equal to 00 select the internal tick, and 11 selects chaining to the timer below. When a lead timer (enable set, code 00) starts, it and the timers directly above it in chain mode reload. Their combined period is the concatenation of their reload bytes, with the lead timer as the least-significant byte.
- R6: Starting a lead timer while a timer directly above it is in chain mode with its enable bit clear is an error, and the access is discarded.
- R7: The underflow pulse of a chain appears only on the `uflow` bit of the highest timer in the chain.
- R8: A mode write that gives timer 0 clock code 11 is an error and is discarded.
- R9: A write to a counter byte is an error and changes no counter.
- R10: `addr[3:2]` selects the register kind (0 mode, 1 reload, 2 counter, 3 unmapped) and `addr[1:0]` selects the timer. `size` codes 0, 1 and 2 mean 1, 2 and 4 bytes. Two-byte access is legal only at timers 0 and 2, and four-byte access only at timer 0. The lower-numbered timer sits in the most-significant byte of the data. Size code 3, the unmapped kind, or a misaligned start is an error; an illegal read returns zero.
- R11: A lead timer whose combined counter is zero stays idle and produces no underflow.
- R12: Counters change only on cycles where `tick` is high, and no underflow follows a cycle with `tick` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for timers on the internal clock |
| wrEn | input | 1 | Write request for this cycle |
| rdEn | input | 1 | Read request for this cycle |
| addr | input | 4 | Register kind in [3:2], timer index in [1:0] |
| size | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2: 4 bytes) |
| wdata | input | 32 | Write data, right-aligned to the access size |
| rdata | output | 32 | Read data, combinational, right-aligned |
| errPulse | output | 1 | One-cycle pulse after an illegal access |
| uflow | output | 4 | Per-timer one-cycle underflow pulse |

## Verification
Read data is combinational, so the bench samples `rdata` in the same cycle as the request. `errPulse` and every `uflow` pulse are registered and are due in the cycle after the clock edge that saw the access or the final tick of a period. Counters move at each edge where `tick` is high. The bench drives inputs just after a falling edge and samples `rdata` before the next rising edge. It reads `errPulse` and `uflow` at the following falling edge, so each expected value is compared exactly one register stage after its cause.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;
  localparam int TMR_N   = 4;
  localparam int BYTE_W  = 8;
  localparam int BUS_W   = TMR_N * BYTE_W;
  localparam int IDX_W   = $clog2(TMR_N);
  localparam int KIND_W  = 2;
  localparam int ADDR_W  = KIND_W + IDX_W;
  localparam int SIZE_W  = 2;
  localparam int CE_BIT  = 7;
  localparam int LD_BIT  = 6;
  localparam int RSV_HI  = 5;
  localparam int RSV_LO  = 2;
  localparam logic [1:0] CLK_INT   = 2'b00;
  localparam logic [1:0] CLK_CHAIN = 2'b11;

  typedef enum logic [KIND_W-1:0] {
    KIND_MODE = 2'd0,
    KIND_BASE = 2'd1,
    KIND_CNT  = 2'd2,
    KIND_NONE = 2'd3
  } reg_kind_e;

  typedef logic [BYTE_W-1:0] byte_t;

  // strobes from control to datapath for one access
  typedef struct packed {
    logic [TMR_N-1:0]             modeWe;
    logic [TMR_N-1:0]             baseWe;
    logic [TMR_N-1:0]             restart;
    logic [TMR_N-1:0][BYTE_W-1:0] wrByte;
  } tmr_strobe_t;
endpackage

// File: rtl/tmr_bank_ctrl.sv
module tmr_bank_ctrl
  import tmr_bank_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic                           rdEn,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [SIZE_W-1:0]              size,
  input  logic [BUS_W-1:0]               wdata,
  input  logic [TMR_N-1:0][BYTE_W-1:0]   modeQ,
  input  logic [TMR_N-1:0][BYTE_W-1:0]   baseQ,
  input  logic [TMR_N-1:0][BYTE_W-1:0]   cntQ,
  output logic [BUS_W-1:0]               rdata,
  output logic                           errPulse,
  output tmr_strobe_t                    strobe
);
  reg_kind_e                   kind;
  logic [IDX_W-1:0]            tIdx;
  int                          nBytes;
  logic                        sizeOk;
  logic [TMR_N-1:0]            sel;
  logic [TMR_N-1:0][BYTE_W-1:0] lane;
  logic [TMR_N-1:0][BYTE_W-1:0] modeNext;
  logic [TMR_N-1:0]            startV;
  logic [TMR_N-1:0]            restartV;
  logic                        modeBad;
  logic                        walk;
  logic                        accessBad;
  logic                        okWr;
  logic                        modeAcc;
  byte_t                       rdVal;

  // address decode and lane steering
  always_comb begin
    kind   = reg_kind_e'(addr[ADDR_W-1 -: KIND_W]);
    tIdx   = addr[IDX_W-1:0];
    nBytes = 1 << size;
    sizeOk = (size != SIZE_W'(3)) && (nBytes <= TMR_N) &&
             ((int'(tIdx) & (nBytes - 1)) == 0);
    sel  = '0;
    lane = '0;
    for (int j = 0; j < TMR_N; j++) begin
      int k;
      k = j - int'(tIdx);
      if (sizeOk && k >= 0 && k < nBytes) begin
        sel[j]  = 1'b1;
        lane[j] = BYTE_W'(wdata >> (BYTE_W * (nBytes - 1 - k)));
      end
    end
  end

  // mode legality, lead start detection, chain readiness
  always_comb begin
    modeAcc  = wrEn && (kind == KIND_MODE);
    modeNext = modeQ;
    modeBad  = 1'b0;
    startV   = '0;
    restartV = '0;
    walk     = 1'b0;
    for (int j = 0; j < TMR_N; j++) begin
      if (modeAcc && sel[j]) begin
        modeNext[j] = lane[j];
        if (lane[j][RSV_HI:RSV_LO] != '0) modeBad = 1'b1;
        if (lane[j][CE_BIT] && lane[j][LD_BIT]) modeBad = 1'b1;
        if (j == 0 && lane[j][1:0] == CLK_CHAIN) modeBad = 1'b1;
        if (lane[j][CE_BIT] && lane[j][1:0] == CLK_INT) startV[j] = 1'b1;
        if (!lane[j][CE_BIT]) restartV[j] = 1'b1;
      end
    end
    for (int j = 0; j < TMR_N; j++) begin
      if (startV[j]) begin
        restartV[j] = 1'b1;
        walk = 1'b1;
        for (int m = j + 1; m < TMR_N; m++) begin
          if (walk && modeNext[m][1:0] == CLK_CHAIN) begin
            if (!modeNext[m][CE_BIT]) modeBad = 1'b1;
            else restartV[m] = 1'b1;
          end else begin
            walk = 1'b0;
          end
        end
      end
    end
  end

  // access verdict and strobes
  always_comb begin
    accessBad = (wrEn || rdEn) &&
                ((kind == KIND_NONE) || !sizeOk ||
                 (wrEn && kind == KIND_CNT) ||
                 (modeAcc && modeBad));
    okWr = wrEn && !accessBad;
    strobe.modeWe  = (okWr && kind == KIND_MODE) ? sel : '0;
    strobe.baseWe  = (okWr && kind == KIND_BASE) ? sel : '0;
    strobe.restart = (okWr && kind == KIND_MODE) ? restartV : '0;
    strobe.wrByte  = lane;
  end

  // read mux
  always_comb begin
    rdata = '0;
    rdVal = '0;
    if (rdEn && !wrEn && !accessBad) begin
      for (int j = 0; j < TMR_N; j++) begin
        if (sel[j]) begin
          unique case (kind)
            KIND_MODE: rdVal = modeQ[j];
            KIND_BASE: rdVal = baseQ[j];
            KIND_CNT:  rdVal = cntQ[j];
            default:   rdVal = '0;
          endcase
          rdata = rdata | (BUS_W'(rdVal) << (BYTE_W * (nBytes - 1 - (j - int'(tIdx)))));
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) errPulse <= 1'b0;
    else       errPulse <= accessBad;
  end
endmodule

// File: rtl/tmr_bank_dp.sv
module tmr_bank_dp
  import tmr_bank_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         tick,
  input  tmr_strobe_t                  strobe,
  output logic [TMR_N-1:0][BYTE_W-1:0] modeQ,
  output logic [TMR_N-1:0][BYTE_W-1:0] baseQ,
  output logic [TMR_N-1:0][BYTE_W-1:0] cntQ,
  output logic [TMR_N-1:0]             uflow
);
  logic [TMR_N-1:0][BYTE_W-1:0] modeR, baseR, cntR;
  logic [TMR_N-1:0] uflowR;
  logic [TMR_N-1:0] isLead, link, isLast;
  logic [TMR_N-1:0] upZero, lowZero, leadGo, go, wrap;

  // chain topology from the stored modes
  always_comb begin
    for (int i = 0; i < TMR_N; i++) begin
      isLead[i] = modeR[i][CE_BIT] && (modeR[i][1:0] == CLK_INT);
      link[i]   = (i > 0) && modeR[i][CE_BIT] && (modeR[i][1:0] == CLK_CHAIN);
    end
    for (int i = 0; i < TMR_N; i++) begin
      isLast[i] = (i == TMR_N - 1) ? 1'b1 : !link[i+1];
    end
  end

  // zero detection above each byte within its chain
  always_comb begin
    upZero = '0;
    for (int i = TMR_N - 1; i >= 0; i--) begin
      if (i == TMR_N - 1) upZero[i] = 1'b1;
      else upZero[i] = link[i+1] ? ((cntR[i+1] == '0) && upZero[i+1]) : 1'b1;
    end
  end

  // borrow, run and wrap propagation from each lead upward
  always_comb begin
    leadGo  = '0;
    go      = '0;
    wrap    = '0;
    lowZero = '0;
    for (int i = 0; i < TMR_N; i++) begin
      leadGo[i] = isLead[i] && tick && !((cntR[i] == '0) && upZero[i]);
      if (i > 0 && link[i]) begin
        go[i]      = go[i-1];
        wrap[i]    = wrap[i-1];
        lowZero[i] = (cntR[i-1] == '0) && lowZero[i-1];
      end else begin
        go[i]      = leadGo[i];
        wrap[i]    = leadGo[i] && (cntR[i] == BYTE_W'(1)) && upZero[i];
        lowZero[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeR  <= '0;
      baseR  <= '0;
      cntR   <= '0;
      uflowR <= '0;
    end else begin
      for (int i = 0; i < TMR_N; i++) begin
        if (strobe.modeWe[i]) modeR[i] <= strobe.wrByte[i];
        if (strobe.baseWe[i]) baseR[i] <= strobe.wrByte[i];
        if (strobe.restart[i])
          cntR[i] <= baseR[i];
        else if (strobe.baseWe[i] && !modeR[i][CE_BIT])
          cntR[i] <= strobe.wrByte[i];
        else if (wrap[i])
          cntR[i] <= baseR[i];
        else if (go[i] && lowZero[i])
          cntR[i] <= cntR[i] - BYTE_W'(1);
        uflowR[i] <= wrap[i] && isLast[i];
      end
    end
  end

  assign modeQ = modeR;
  assign baseQ = baseR;
  assign cntQ  = cntR;
  assign uflow = uflowR;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              errPulse,
  output logic [TMR_N-1:0]  uflow
);
  tmr_strobe_t                  strobe;
  logic [TMR_N-1:0][BYTE_W-1:0] modeQ, baseQ, cntQ;

  tmr_bank_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .size(size), .wdata(wdata), .modeQ(modeQ), .baseQ(baseQ),
    .cntQ(cntQ), .rdata(rdata), .errPulse(errPulse), .strobe(strobe)
  );

  tmr_bank_dp dp_i (
    .clk(clk), .rstN(rstN), .tick(tick), .strobe(strobe),
    .modeQ(modeQ), .baseQ(baseQ), .cntQ(cntQ), .uflow(uflow)
  );
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
  import tmr_bank_pkg::*;
(
  input logic                         clk,
  input logic                         rstN,
  input logic                         tick,
  input logic                         wrEn,
  input logic [ADDR_W-1:0]            addr,
  input logic                         errPulse,
  input logic [TMR_N-1:0]             uflow,
  input logic [TMR_N-1:0][BYTE_W-1:0] modeQ,
  input logic [TMR_N-1:0][BYTE_W-1:0] baseQ,
  input logic [TMR_N-1:0][BYTE_W-1:0] cntQ
);
  // R9
  cnt_write_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[ADDR_W-1 -: KIND_W] == KIND_CNT) |=> errPulse);

  // R12
  no_tick_no_uflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> (uflow == '0));

  // R8
  lead0_never_chained_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeQ[0][1:0] != CLK_CHAIN);

  for (genvar g = 0; g < TMR_N; g++) begin : g_tmr
    // R2
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
      (modeQ[g][RSV_HI:RSV_LO] == '0) && !(modeQ[g][CE_BIT] && modeQ[g][LD_BIT]));

    // R4
    stopped_reads_base_chk: assert property (@(posedge clk) disable iff (!rstN)
      !modeQ[g][CE_BIT] |-> (cntQ[g] == baseQ[g]));

    if (g < TMR_N - 1) begin : g_up
      // R7
      uflow_on_top_chk: assert property (@(posedge clk) disable iff (!rstN)
        uflow[g] |-> $past(!(modeQ[g+1][CE_BIT] && modeQ[g+1][1:0] == CLK_CHAIN)));
    end
  end
endmodule

bind tmr_bank tmr_bank_chk chk_i (
  .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
  .errPulse(errPulse), .uflow(uflow), .modeQ(modeQ), .baseQ(baseQ), .cntQ(cntQ)
);

// File: tb/tmr_bank_tb_top.sv
module tmr_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int RAND_ITERS = 300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        errPulse;
  logic [3:0]  uflow;

  int nCmp = 0;
  int nBad = 0;
  int ufCnt [4];
  logic [7:0] shMode [4];
  logic [7:0] shBase [4];
  logic [7:0] shCnt  [4];
  logic [31:0] rdv;
  bit          ev;

  tmr_bank dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .size(size), .wdata(wdata), .rdata(rdata),
    .errPulse(errPulse), .uflow(uflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  // one access; rdata sampled before the rising edge, errPulse one cycle later
  task automatic acc(input bit wr, input int kind, input int t, input int sz,
                     input logic [31:0] d, output logic [31:0] rd, output bit e);
    @(negedge clk);
    wrEn  = wr;
    rdEn  = !wr;
    addr  = 4'((kind << 2) | t);
    size  = 2'(sz);
    wdata = d;
    #1 rd = rdata;
    @(negedge clk);
    e     = errPulse;
    wrEn  = 1'b0;
    rdEn  = 1'b0;
  endtask

  task automatic wrOk(input string req, input int kind, input int t, input int sz, input logic [31:0] d);
    logic [31:0] r;
    bit e;
    acc(1'b1, kind, t, sz, d, r, e);
    check(req, 32'(e), 32'd0);
  endtask

  task automatic rdChk(input string req, input int kind, input int t, input int sz, input logic [31:0] exp);
    logic [31:0] r;
    bit e;
    acc(1'b0, kind, t, sz, 32'd0, r, e);
    check(req, r, exp);
  endtask

  task automatic errChk(input string req, input bit wr, input int kind, input int t, input int sz, input logic [31:0] d);
    logic [31:0] r;
    bit e;
    acc(wr, kind, t, sz, d, r, e);
    check(req, 32'(e), 32'd1);
    if (!wr) check(req, r, 32'd0);
  endtask

  // n rising edges with tick high; pulses tallied per timer
  task automatic run(input int n);
    for (int i = 0; i < 4; i++) ufCnt[i] = 0;
    @(negedge clk);
    tick = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) if (uflow[i]) ufCnt[i]++;
    end
    tick = 1'b0;
  endtask

  function automatic bit legalAcc(bit wr, int kind, int t, int sz, logic [31:0] d);
    int n;
    logic [7:0] b;
    if (kind == 3 || sz == 3) return 1'b0;
    n = 1 << sz;
    if ((t % n) != 0) return 1'b0;
    if (wr && kind == 2) return 1'b0;
    if (wr && kind == 0) begin
      for (int k = 0; k < n; k++) begin
        b = d[8*(n-1-k) +: 8];
        if (b[5:2] != 4'd0 || (b[7] && b[6])) return 1'b0;
        if (t + k == 0 && b[1:0] == 2'b11) return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  function automatic logic [31:0] expRead(int kind, int t, int sz);
    int n;
    logic [31:0] r;
    logic [7:0] v;
    n = 1 << sz;
    r = '0;
    for (int k = 0; k < n; k++) begin
      v = (kind == 0) ? shMode[t+k] : (kind == 1) ? shBase[t+k] : shCnt[t+k];
      r = r | (32'(v) << (8*(n-1-k)));
    end
    return r;
  endfunction

  task automatic applyWr(int kind, int t, int sz, logic [31:0] d);
    int n;
    logic [7:0] b;
    n = 1 << sz;
    for (int k = 0; k < n; k++) begin
      b = d[8*(n-1-k) +: 8];
      if (kind == 0) begin
        shMode[t+k] = b;
        if (!b[7]) shCnt[t+k] = shBase[t+k];
      end else begin
        shBase[t+k] = b;
        if (!shMode[t+k][7]) shCnt[t+k] = b;
      end
    end
  endtask

  function automatic logic [7:0] modePick();
    logic [7:0] pool [14] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h40, 8'h41, 8'h43,
                              8'h81, 8'h82, 8'h83, 8'hC0, 8'h04, 8'h20, 8'hC3};
    return pool[$urandom_range(0, 13)];
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin
      shMode[i] = '0; shBase[i] = '0; shCnt[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 uflow", 32'(uflow), 32'd0);
    check("R1 err", 32'(errPulse), 32'd0);
    rdChk("R1 mode", 0, 0, 2, 32'd0);
    rdChk("R1 base", 1, 0, 2, 32'd0);
    rdChk("R1 cnt",  2, 0, 2, 32'd0);

    // random register traffic with counting idle (R2 R3 R8 R9 R10)
    for (int it = 0; it < RAND_ITERS; it++) begin
      bit wr;
      int kind, t, sz;
      logic [31:0] d;
      bit lg;
      wr   = $urandom_range(0, 1) == 1;
      kind = ($urandom_range(0, 9) < 8) ? $urandom_range(0, 2) : 3;
      t    = $urandom_range(0, 3);
      sz   = ($urandom_range(0, 9) < 8) ? $urandom_range(0, 2) : 3;
      d    = $urandom;
      if (kind == 0) d = {modePick(), modePick(), modePick(), modePick()};
      lg = legalAcc(wr, kind, t, sz, d);
      acc(wr, kind, t, sz, d, rdv, ev);
      check("R10 random err", 32'(ev), 32'(!lg));
      if (!wr) check("R10 random rdata", rdv, lg ? expRead(kind, t, sz) : 32'd0);
      if (wr && lg) applyWr(kind, t, sz, d);
    end

    // clean slate
    wrOk("R10 clear modes", 0, 0, 2, 32'h0);
    wrOk("R10 clear bases", 1, 0, 2, 32'h0);

    // R3 reload write while stopped loads counter
    wrOk("R3 base0", 1, 0, 0, 32'h05);
    rdChk("R3 stopped load", 2, 0, 0, 32'h05);

    // R4 count and reload, period 5
    wrOk("R4 start0", 0, 0, 0, 32'h80);
    run(12);
    check("R4 uflow count", 32'(ufCnt[0]), 32'd2);
    rdChk("R4 counter after 12", 2, 0, 0, 32'h03);

    // R3 new reload while running takes effect at next reload
    wrOk("R3 base0 running", 1, 0, 0, 32'h07);
    rdChk("R3 counter untouched", 2, 0, 0, 32'h03);
    run(4);
    check("R3 one reload", 32'(ufCnt[0]), 32'd1);
    rdChk("R3 new reload used", 2, 0, 0, 32'h06);

    // R4 stopping reads reload value
    wrOk("R4 stop0", 0, 0, 0, 32'h00);
    rdChk("R4 stopped reads base", 2, 0, 0, 32'h07);

    // R12 tick gating
    wrOk("R12 start0", 0, 0, 0, 32'h80);
    repeat (5) @(negedge clk);
    check("R12 no uflow idle", 32'(uflow), 32'd0);
    rdChk("R12 held", 2, 0, 0, 32'h07);
    run(2);
    rdChk("R12 two ticks", 2, 0, 0, 32'h05);
    wrOk("R12 stop0", 0, 0, 0, 32'h00);

    // R5 R7 16-bit chain, period 0x0102
    wrOk("R10 two-byte base", 1, 0, 1, 32'h0201);
    wrOk("R5 follower", 0, 1, 0, 32'h83);
    wrOk("R5 lead", 0, 0, 0, 32'h80);
    rdChk("R5 start value", 2, 0, 1, 32'h0201);
    run(3);
    rdChk("R5 borrow across bytes", 2, 0, 1, 32'hFF00);
    check("R7 no early pulse", 32'(ufCnt[0] + ufCnt[1]), 32'd0);
    run(255);
    check("R7 chain top pulse", 32'(ufCnt[1]), 32'd1);
    check("R7 lead silent", 32'(ufCnt[0]), 32'd0);
    rdChk("R5 reloaded", 2, 0, 1, 32'h0201);
    wrOk("R10 two-byte mode stop", 0, 0, 1, 32'h0000);

    // R7 R10 24-bit chain on timers 1..3 set by four-byte writes, period 3
    wrOk("R10 four-byte base", 1, 0, 2, 32'h00030000);
    wrOk("R10 four-byte mode", 0, 0, 2, 32'h00808383);
    rdChk("R10 four-byte read", 0, 0, 2, 32'h00808383);
    run(7);
    check("R7 top of 24-bit chain", 32'(ufCnt[3]), 32'd2);
    check("R7 lower chain silent", 32'(ufCnt[1] + ufCnt[2]), 32'd0);
    wrOk("R10 stop all", 0, 0, 2, 32'h0);

    // R6 follower not enabled
    wrOk("R6 follower off", 0, 2, 0, 32'h03);
    errChk("R6 start refused", 1'b1, 0, 1, 0, 32'h80);
    rdChk("R6 mode1 kept", 0, 1, 0, 32'h00);
    wrOk("R6 clear", 0, 2, 0, 32'h00);

    // R8 timer 0 chain code
    errChk("R8 chain on timer0", 1'b1, 0, 0, 0, 32'h83);
    rdChk("R8 mode0 kept", 0, 0, 0, 32'h00);

    // R2 illegal mode bytes
    errChk("R2 enable+load", 1'b1, 0, 3, 0, 32'hC0);
    errChk("R2 reserved bit", 1'b1, 0, 3, 0, 32'h10);
    rdChk("R2 mode3 kept", 0, 3, 0, 32'h00);

    // R9 counter write
    errChk("R9 counter write", 1'b1, 2, 0, 0, 32'h55);
    rdChk("R9 counter kept", 2, 0, 0, 32'h00);

    // R10 bad sizes and addresses
    errChk("R10 two-byte at 1", 1'b1, 0, 1, 1, 32'h0000);
    errChk("R10 four-byte at 2", 1'b0, 1, 2, 2, 32'h0);
    errChk("R10 size code 3", 1'b0, 1, 0, 3, 32'h0);
    errChk("R10 unmapped", 1'b0, 3, 0, 0, 32'h0);

    // R11 zero period idle
    wrOk("R11 base zero", 1, 0, 0, 32'h00);
    wrOk("R11 start", 0, 0, 0, 32'h80);
    run(10);
    check("R11 no uflow", 32'(ufCnt[0] + ufCnt[1] + ufCnt[2] + ufCnt[3]), 32'd0);
    rdChk("R11 counter zero", 2, 0, 0, 32'h00);

    summary();
  end
endmodule